// File: doc/BRIEF.md
# Run-Mode Clock Source Controller

This block decides which oscillator clocks a small microcontroller while it runs. Normally the system runs from the primary oscillator. A sleep command, issued with the select bits that ask for internal-oscillator run mode, moves the clock to the internal oscillator multiplexer and shuts the primary oscillator down, so code keeps running at lower power. A later wake-up event starts the primary oscillator again. The controller keeps the internal source in use until the primary side reports ready, then hands the clock back.

The frequency-select field picks the internal frequency at any time. A value of zero turns the multiplexer output off and leaves the low-frequency RC source driving the clock. A nonzero value turns the output on, and a stabilization counter raises the internal-stable flag once the output has settled. The low-frequency RC source is also held on while the watchdog or the fail-safe monitor is enabled. The oscillators themselves and the glitch-free clock mux are outside this block. They appear only as enables, a source select and ready inputs, all in the system clock domain. Every output is registered and changes on the clock edge after the inputs that cause it.

Top module: `clksrc_ctrl`

## Requirements
- R1: Internal-oscillator run mode is entered only when `sleep_cmd_i` is high, `idle_en_i` is low and `clk_sel_i[1]` is high, sampled in the same cycle in primary run. `clk_sel_i[0]` has no effect on this decision. Any other sleep command leaves the clock on the primary source.
- R2: On entry, at the next edge, `src_sel_o` leaves 0 (0 = primary, 1 = internal multiplexer, 2 = low-frequency RC), `pri_osc_en_o` drops to 0, `pri_started_o` clears and `switch_done_o` pulses high for exactly one cycle.
- R3: While `freq_sel_i` is all zero, `int_out_en_o` and `int_stable_o` are 0 one cycle later. In internal run, `src_sel_o` is 2 and `lfrc_en_o` is 1.
- R4: When `freq_sel_i` goes from zero to nonzero, the clock stays internal with `src_sel_o` = 1 and no gap. `int_stable_o` rises on the STAB_CYCLES-th edge after the change and not before.
- R5: If `int_stable_o` is already set when internal run is entered with a nonzero frequency, it stays set across the entry.
- R6: After a wake-up in internal run, `pri_osc_en_o` goes to 1 at the next edge. `src_sel_o` stays nonzero until `pri_ready_i` has been seen high.
- R7: The edge that completes the return to the primary clock sets `src_sel_o` to 0 and `pri_started_o` to 1, clears `int_stable_o`, and pulses `switch_done_o` for one cycle.
- R8: `lfrc_en_o` is 1 one cycle after any cycle in which `wdog_en_i` or `failsafe_en_i` is high, in every mode.
- R9: `freq_o` follows `freq_sel_i` one cycle later in any mode, with no sleep command. A change between two nonzero values keeps `int_stable_o` as it was.
- R10: `wake_i` in primary run has no effect, and a sleep command in internal run has no effect: `src_sel_o` and `pri_started_o` hold.
- R11: Synchronous reset gives primary run: `src_sel_o` = 0, `pri_osc_en_o` = 1, `pri_started_o` = 1, `int_stable_o` = 0, `int_out_en_o` = 0, `switch_done_o` = 0, `lfrc_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_en_i | input | 1 | Idle-enable control bit; must be low to enter internal run |
| clk_sel_i | input | 2 | System clock select; bit 1 requests internal run, bit 0 unused |
| freq_sel_i | input | FREQ_W | Internal frequency select; zero disables the multiplexer output |
| sleep_cmd_i | input | 1 | One-cycle sleep command |
| wake_i | input | 1 | Wake-up event |
| pri_ready_i | input | 1 | Primary oscillator ready |
| wdog_en_i | input | 1 | Watchdog enabled |
| failsafe_en_i | input | 1 | Fail-safe clock monitor enabled |
| src_sel_o | output | 2 | Active source: 0 primary, 1 internal multiplexer, 2 low-frequency RC |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| int_out_en_o | output | 1 | Internal multiplexer output enable |
| lfrc_en_o | output | 1 | Low-frequency RC source enable |
| freq_o | output | FREQ_W | Internal frequency currently applied |
| int_stable_o | output | 1 | Internal source stable flag |
| pri_started_o | output | 1 | Primary oscillator start-up flag |
| switch_done_o | output | 1 | One-cycle pulse when a source switch completes |

## Verification
The bench builds the block with STAB_CYCLES = 12 and the default FREQ_W = 3. This shortens the roughly 1 ms settling interval, so the exact edge on which the stable flag rises can be checked both after a zero-to-nonzero write and after the flag has been re-qualified in primary run. The short count also leaves room in one run for an entry that keeps a stable flag across the sleep command. With three select bits the bench can step between nonzero frequencies and back to zero. That covers the immediate-change rule and the low-frequency fallback.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic [1:0] {
    ST_PRI = 2'd0,
    ST_INT = 2'd1,
    ST_SW  = 2'd2
  } run_state_e;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_MUX = 2'd1,
    SRC_LF  = 2'd2
  } clk_src_e;
endpackage

// File: rtl/clksrc_entry_dec.sv
module clksrc_entry_dec #(
  parameter int SEL_W = 2
) (
  input  logic             sleep_cmd_i,
  input  logic             idle_en_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  output logic             enter_req_o
);
  localparam int REQ_BIT = SEL_W - 1;

  // only the top select bit matters; lower bits are don't-care
  assign enter_req_o = sleep_cmd_i & ~idle_en_i & clk_sel_i[REQ_BIT];
endmodule

// File: rtl/clksrc_fsm.sv
module clksrc_fsm
  import clksrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enter_req_i,
  input  logic       wake_i,
  input  logic       pri_ready_i,
  output run_state_e state_o,
  output run_state_e state_n_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PRI:  if (enter_req_i) state_d = ST_INT;
      ST_INT:  if (wake_i)      state_d = ST_SW;
      ST_SW:   if (pri_ready_i) state_d = ST_PRI;
      default: state_d = ST_PRI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PRI;
    else     state_q <= state_d;
  end

  assign state_o   = state_q;
  assign state_n_o = state_d;

  // R6
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SW && !pri_ready_i) |=> (state_q == ST_SW));

  // R10
  wake_in_pri_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRI && !enter_req_i) |=> (state_q == ST_PRI));
endmodule

// File: rtl/clksrc_stab.sv
module clksrc_stab #(
  parameter int STAB_CYCLES = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic freq_nz_i,
  input  logic clear_i,
  output logic stable_o
);
  localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES + 1) : 1;

  logic stable_q;

  generate
    if (STAB_CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || !freq_nz_i || clear_i) stable_q <= 1'b0;
        else                              stable_q <= 1'b1;
      end
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || !freq_nz_i || clear_i) begin
          cnt_q    <= '0;
          stable_q <= 1'b0;
        end else if (!stable_q) begin
          if (cnt_q == LAST) stable_q <= 1'b1;
          else               cnt_q    <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign stable_o = stable_q;

  // R4
  stable_needs_freq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stable_q) |-> $past(freq_nz_i));
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int FREQ_W      = 3,
  parameter int STAB_CYCLES = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic [FREQ_W-1:0] freq_sel_i,
  input  logic              sleep_cmd_i,
  input  logic              wake_i,
  input  logic              pri_ready_i,
  input  logic              wdog_en_i,
  input  logic              failsafe_en_i,
  output logic [1:0]        src_sel_o,
  output logic              pri_osc_en_o,
  output logic              int_out_en_o,
  output logic              lfrc_en_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              int_stable_o,
  output logic              pri_started_o,
  output logic              switch_done_o
);
  logic       enter_req;
  logic       freq_nz;
  logic       enter_done;
  logic       back_done;
  run_state_e st, st_n;
  clk_src_e   src_d;

  assign freq_nz = |freq_sel_i;

  clksrc_entry_dec #(.SEL_W(2)) u_dec (
    .sleep_cmd_i (sleep_cmd_i),
    .idle_en_i   (idle_en_i),
    .clk_sel_i   (clk_sel_i),
    .enter_req_o (enter_req)
  );

  clksrc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .enter_req_i (enter_req),
    .wake_i      (wake_i),
    .pri_ready_i (pri_ready_i),
    .state_o     (st),
    .state_n_o   (st_n)
  );

  assign enter_done = (st == ST_PRI) && (st_n == ST_INT);
  assign back_done  = (st == ST_SW)  && (st_n == ST_PRI);

  clksrc_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk       (clk),
    .rst       (rst),
    .freq_nz_i (freq_nz),
    .clear_i   (back_done),
    .stable_o  (int_stable_o)
  );

  always_comb begin
    if (st_n == ST_PRI) src_d = SRC_PRI;
    else if (freq_nz)   src_d = SRC_MUX;
    else                src_d = SRC_LF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel_o     <= SRC_PRI;
      pri_osc_en_o  <= 1'b1;
      int_out_en_o  <= 1'b0;
      lfrc_en_o     <= 1'b0;
      freq_o        <= '0;
      pri_started_o <= 1'b1;
      switch_done_o <= 1'b0;
    end else begin
      src_sel_o     <= src_d;
      pri_osc_en_o  <= (st_n != ST_INT);
      int_out_en_o  <= freq_nz;
      lfrc_en_o     <= ((st_n != ST_PRI) && !freq_nz) || wdog_en_i || failsafe_en_i;
      freq_o        <= freq_sel_i;
      switch_done_o <= enter_done || back_done;
      if (enter_done)     pri_started_o <= 1'b0;
      else if (back_done) pri_started_o <= 1'b1;
    end
  end

  // R2
  pri_off_not_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !pri_osc_en_o |-> (src_sel_o != SRC_PRI));

  // R3
  stable_needs_output_chk: assert property (@(posedge clk) disable iff (rst)
    !int_out_en_o |-> !int_stable_o);

  // R6
  stay_internal_chk: assert property (@(posedge clk) disable iff (rst)
    (src_sel_o != SRC_PRI && !pri_ready_i) |=> (src_sel_o != SRC_PRI));

  // R7
  start_flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pri_started_o) |-> (switch_done_o && src_sel_o == SRC_PRI));

  // R8
  lf_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (wdog_en_i || failsafe_en_i) |=> lfrc_en_o);
endmodule

// File: tb/tb_clksrc_ctrl.sv
`timescale 1ns/1ps
module tb_clksrc_ctrl;
  localparam int FW   = 3;
  localparam int STAB = 12;

  localparam int F_SRC = 0, F_PEN = 1, F_IEN = 2, F_LF = 3,
                 F_STB = 4, F_PST = 5, F_DON = 6, F_FRQ = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_en = 1'b0, sleep_cmd = 1'b0, wake = 1'b0, pri_ready = 1'b0;
  logic wdog_en = 1'b0, fs_en = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic [FW-1:0] freq_sel = '0;

  logic [1:0] src_sel;
  logic pri_osc_en, int_out_en, lfrc_en, int_stable, pri_started, switch_done;
  logic [FW-1:0] freq_out;

  clksrc_ctrl #(.FREQ_W(FW), .STAB_CYCLES(STAB)) dut (
    .clk(clk), .rst(rst), .idle_en_i(idle_en), .clk_sel_i(clk_sel),
    .freq_sel_i(freq_sel), .sleep_cmd_i(sleep_cmd), .wake_i(wake),
    .pri_ready_i(pri_ready), .wdog_en_i(wdog_en), .failsafe_en_i(fs_en),
    .src_sel_o(src_sel), .pri_osc_en_o(pri_osc_en), .int_out_en_o(int_out_en),
    .lfrc_en_o(lfrc_en), .freq_o(freq_out), .int_stable_o(int_stable),
    .pri_started_o(pri_started), .switch_done_o(switch_done)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    cyc;
    int    fld;
    int    val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  function automatic int get_field(int f);
    case (f)
      F_SRC:   return int'(src_sel);
      F_PEN:   return int'(pri_osc_en);
      F_IEN:   return int'(int_out_en);
      F_LF:    return int'(lfrc_en);
      F_STB:   return int'(int_stable);
      F_PST:   return int'(pri_started);
      F_DON:   return int'(switch_done);
      default: return int'(freq_out);
    endcase
  endfunction

  // driver side: queue an expectation for the edge that follows
  task automatic expect_f(int f, int v, string req);
    exp_t e;
    e.cyc = cyc + 1;
    e.fld = f;
    e.val = v;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic go();
    @(negedge clk);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      int got;
      e = q.pop_front();
      got = get_field(e.fld);
      tests++;
      if (got != e.val) begin
        fails++;
        $display("FAIL %s field %0d cycle %0d: got %0d expected %0d",
                 e.req, e.fld, cyc, got, e.val);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    go();
    expect_f(F_SRC, 0, "R11"); expect_f(F_PEN, 1, "R11"); expect_f(F_IEN, 0, "R11");
    expect_f(F_STB, 0, "R11"); expect_f(F_PST, 1, "R11"); expect_f(F_DON, 0, "R11");
    expect_f(F_LF, 0, "R11");
    go(); rst = 1'b0;

    // R1 sleep with idle set is not an entry
    go(); sleep_cmd = 1; idle_en = 1; clk_sel = 2'b10;
    expect_f(F_SRC, 0, "R1"); expect_f(F_PST, 1, "R1");
    // R1 sleep with high select bit clear is not an entry
    go(); idle_en = 0; clk_sel = 2'b01;
    expect_f(F_SRC, 0, "R1"); expect_f(F_PEN, 1, "R1");
    // R10 wake in primary run
    go(); sleep_cmd = 0; wake = 1;
    expect_f(F_SRC, 0, "R10"); expect_f(F_PST, 1, "R10");
    go(); wake = 0;

    // R1 R2 R3 entry with low select bit set, frequency zero
    go(); sleep_cmd = 1; clk_sel = 2'b11; freq_sel = '0;
    expect_f(F_SRC, 2, "R2"); expect_f(F_PEN, 0, "R2"); expect_f(F_PST, 0, "R2");
    expect_f(F_DON, 1, "R2"); expect_f(F_LF, 1, "R3"); expect_f(F_IEN, 0, "R3");
    expect_f(F_STB, 0, "R3");
    go(); sleep_cmd = 0;
    expect_f(F_DON, 0, "R2");

    // R10 sleep in internal run
    go(); sleep_cmd = 1;
    expect_f(F_SRC, 2, "R10"); expect_f(F_DON, 0, "R10");
    go(); sleep_cmd = 0;

    // R4 stabilization from zero to nonzero
    for (int k = 1; k <= STAB; k++) begin
      go();
      if (k == 1) begin
        freq_sel = 3'd3;
        expect_f(F_SRC, 1, "R4"); expect_f(F_IEN, 1, "R4");
        expect_f(F_LF, 0, "R4"); expect_f(F_FRQ, 3, "R9");
      end
      expect_f(F_STB, (k == STAB) ? 1 : 0, "R4");
    end

    // R9 nonzero to nonzero keeps stable, applies at once
    go(); freq_sel = 3'd5;
    expect_f(F_FRQ, 5, "R9"); expect_f(F_STB, 1, "R9"); expect_f(F_SRC, 1, "R9");

    // R6 wake keeps internal until ready
    go(); wake = 1;
    expect_f(F_SRC, 1, "R6"); expect_f(F_PEN, 1, "R6"); expect_f(F_PST, 0, "R6");
    go(); wake = 0;
    for (int k = 0; k < 3; k++) begin
      go();
      expect_f(F_SRC, 1, "R6");
    end

    // R7 completion
    go(); pri_ready = 1;
    expect_f(F_SRC, 0, "R7"); expect_f(F_PST, 1, "R7"); expect_f(F_STB, 0, "R7");
    expect_f(F_DON, 1, "R7"); expect_f(F_PEN, 1, "R7");
    go(); pri_ready = 0;
    expect_f(F_DON, 0, "R7");

    // stable re-qualifies in primary run
    for (int k = 2; k <= STAB; k++) begin
      go();
      if (k >= STAB - 1) expect_f(F_STB, (k == STAB) ? 1 : 0, "R4");
    end

    // R5 entry with stable already set
    go(); sleep_cmd = 1; clk_sel = 2'b10;
    expect_f(F_STB, 1, "R5"); expect_f(F_SRC, 1, "R5");
    expect_f(F_PEN, 0, "R5"); expect_f(F_DON, 1, "R5");
    go(); sleep_cmd = 0;

    // R3 frequency back to zero in internal run
    go(); freq_sel = '0;
    expect_f(F_SRC, 2, "R3"); expect_f(F_IEN, 0, "R3");
    expect_f(F_STB, 0, "R3"); expect_f(F_LF, 1, "R3");

    // R6 wake with ready already high: one cycle on internal first
    go(); wake = 1; pri_ready = 1;
    expect_f(F_SRC, 2, "R6"); expect_f(F_PEN, 1, "R6");
    go(); wake = 0;
    expect_f(F_SRC, 0, "R7"); expect_f(F_DON, 1, "R7"); expect_f(F_PST, 1, "R7");
    go(); pri_ready = 0;

    // R8 low-frequency source held by watchdog or fail-safe
    go(); wdog_en = 1;
    expect_f(F_LF, 1, "R8");
    go(); wdog_en = 0; fs_en = 1;
    expect_f(F_LF, 1, "R8");
    go(); fs_en = 0;
    expect_f(F_LF, 0, "R8");

    go(); go(); go();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule